// File: doc/BRIEF.md
# Prescaled Periodic Countdown Timer

A single-channel countdown timer that sits on a simple 32-bit register bus (address, write strobe, write data, combinational read data). Software programs a start value, picks a power-of-two clock divider and chooses between periodic and one-shot operation. While enabled, the counter steps down once per divided tick. When a step takes it from one to zero, a sticky status flag is set and drives a level interrupt line.

In periodic mode the counter refills from the start value on every expiry, so an interrupt handler only needs to clear the flag. It may also rewrite the start value, and that write restarts the countdown at once. In one-shot mode the counter rests at zero after expiring. Turning the enable off freezes the count and restarts the divider. Turning it back on continues from the frozen value.

Top module: `cdt_timer`

## Requirements
- R1: Registers decode at byte offsets 0x00 (status), 0x10 (start value) and 0x18 (control). A read of any other offset returns zero, and a write to one changes nothing.
- R2: Control bit 7 is enable, bit 4 is periodic mode and bits 3:0 are the divider select. All other control bits read as zero, so a read-modify-write that sets bit 7 leaves the other fields intact.
- R3: With divider select s, the counter steps once every 2^(s+1) clocks. Select 0 gives 2 and select 14 gives 32768.
- R4: A counter loaded with N expires on the N*2^(s+1)-th rising edge after the edge that registers the enable. The status flag (status bit 0) is set on that edge.
- R5: In periodic mode, expiries repeat every N*2^(s+1) clocks. In one-shot mode the counter holds zero after expiry and no further expiry occurs.
- R6: The `irq` output follows the status flag. Writing 1 to status bit 0 clears the flag, and writing 0 has no effect. If an expiry and a clear fall on the same edge, the flag stays set.
- R7: A write to the start-value register reloads the counter and restarts the divider, even while the counter runs. The next expiry comes N*2^(s+1) edges after that write.
- R8: Clearing enable freezes the counter and resets the divider. Re-enabling resumes from the frozen count, and the first step takes a full divider period.
- R9: Reset clears the control, start-value and status registers and drives `irq` low.
- R10: The start-value register keeps the low CNT_W bits of a write. Higher bits read as zero.
- R11: A counter at zero never steps and never expires, even when enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Byte offset of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the addressed register, combinational |
| irq | output | 1 | Level interrupt, high while the status flag is set |

## Verification
The bench builds the timer with CNT_W set to 8, so the truncation of wide start-value writes shows in the readback. Divider selects 0, 2 and 14 are all exercised; select 14 costs 32768 clocks per step, which fits the run only because the start value is 1. The expiry edge is known exactly, which lets the bench land a clear write on that same edge and land a disable partway through a divider period.

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam int PRE_W = 16;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h18);

  logic             en, periodic, flag;
  logic [3:0]       psel;
  logic [CNT_W-1:0] load_q, cnt;
  logic [PRE_W-1:0] pre, pre_lim;
  logic             tick, expire, wr_stat, wr_load, wr_ctrl;

  assign wr_stat = wr_en && (addr == A_STAT);
  assign wr_load = wr_en && (addr == A_LOAD);
  assign wr_ctrl = wr_en && (addr == A_CTRL);

  assign pre_lim = PRE_W'((32'd2 << psel) - 32'd1);
  assign tick    = en && (pre == pre_lim);
  assign expire  = tick && (cnt == CNT_W'(1));
  assign irq     = flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      periodic <= 1'b0;
      psel     <= '0;
      load_q   <= '0;
      cnt      <= '0;
      pre      <= '0;
      flag     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en       <= wr_data[7];
        periodic <= wr_data[4];
        psel     <= wr_data[3:0];
      end
      if (wr_load) load_q <= wr_data[CNT_W-1:0];

      if (!en || tick || wr_load) pre <= '0;
      else                        pre <= pre + PRE_W'(1);

      if (wr_load)
        cnt <= wr_data[CNT_W-1:0];
      else if (tick && cnt != '0)
        cnt <= expire ? (periodic ? load_q : '0) : cnt - CNT_W'(1);

      flag <= (flag && !(wr_stat && wr_data[0])) || expire;
    end
  end

  always_comb begin
    case (addr)
      A_STAT:  rd_data = {31'b0, flag};
      A_LOAD:  rd_data = 32'(load_q);
      A_CTRL:  rd_data = {24'b0, en, 2'b0, periodic, psel};
      default: rd_data = 32'b0;
    endcase
  end
endmodule

module cdt_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic              irq,
  input logic              en,
  input logic              expire,
  input logic [CNT_W-1:0]  cnt
);
  logic clr_wr, load_wr;
  assign clr_wr  = wr_en && addr == ADDR_W'('h00) && wr_data[0];
  assign load_wr = wr_en && addr == ADDR_W'('h10);

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !expire) |=> !irq);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_wr) |=> irq);
  assert_expire_sets_R4: assert property (@(posedge clk) disable iff (rst)
    expire |=> irq);
  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    load_wr |=> cnt == $past(wr_data[CNT_W-1:0]));
  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (!en && !load_wr) |=> $stable(cnt));
  assert_ctrl_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'('h18)) |-> (rd_data[31:8] == 24'b0 && rd_data[6:5] == 2'b0));
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .irq(irq), .en(en), .expire(expire), .cnt(cnt)
);

// File: tb/sim_cdt_timer.sv
`timescale 1ns/1ps
module sim_cdt_timer;
  localparam int CW = 8;
  localparam int MASK = (1 << CW) - 1;

  logic        clk = 0, rst = 1, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wr_data = 0;
  wire  [31:0] rd_data;
  wire         irq;

  always #2.5 clk = ~clk;

  cdt_timer #(.CNT_W(CW), .ADDR_W(8)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  int checks = 0, errors = 0, cyc = 0;
  int m_en, m_per, m_sel, m_load, m_cnt, m_pre, m_flag;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rd(logic [7:0] a);
    case (a)
      8'h00: return m_flag;
      8'h10: return m_load;
      8'h18: return (m_en << 7) | (m_per << 4) | m_sel;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int d;
    bit tk, ex, wl, ws, wc;
    cyc++;
    if (rst) begin
      m_en = 0; m_per = 0; m_sel = 0; m_load = 0; m_cnt = 0; m_pre = 0; m_flag = 0;
    end else begin
      d  = 2 ** (m_sel + 1);
      tk = m_en != 0 && m_pre == d - 1;
      ex = tk && m_cnt == 1;
      wl = wr_en && addr == 8'h10;
      ws = wr_en && addr == 8'h00;
      wc = wr_en && addr == 8'h18;
      m_pre = (m_en == 0 || tk || wl) ? 0 : m_pre + 1;
      if (wl) m_cnt = int'(wr_data) & MASK;
      else if (tk && m_cnt != 0) m_cnt = (m_cnt == 1) ? (m_per != 0 ? m_load : 0) : m_cnt - 1;
      m_flag = ((m_flag != 0 && !(ws && wr_data[0])) || ex) ? 1 : 0;
      if (wc) begin m_en = wr_data[7]; m_per = wr_data[4]; m_sel = wr_data[3:0]; end
      if (wl) m_load = int'(wr_data) & MASK;
    end
    #1;
    chk("R6 per-cycle irq", irq, m_flag);
    chk("R1 per-cycle rd_data", rd_data, exp_rd(addr));
  end

  task automatic drive(logic [7:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    drive(a, d);
  endtask

  task automatic wr_at(int x, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    while (cyc < x - 1) @(negedge clk);
    drive(a, d);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rd_data;
  endtask

  task automatic wait_rise(output int t);
    while (irq !== 1'b1) begin @(posedge clk); #1; end
    t = cyc;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired at cycle %0d expected finish", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int e, t, t1, t2, t3;
    repeat (3) @(negedge clk);
    rst = 0;
    rd(8'h00, v); chk("R9 status after reset", v, 0);
    rd(8'h10, v); chk("R9 load after reset", v, 0);
    rd(8'h18, v); chk("R9 ctrl after reset", v, 0);
    chk("R9 irq after reset", irq, 0);

    wr(8'h10, 32'h7700_0103);
    rd(8'h10, v); chk("R10 load truncated", v, 3);
    wr(8'h18, 32'h0000_FF61);
    rd(8'h18, v); chk("R2 ctrl unused bits", v, 32'h01);
    wr(8'h18, 32'h12);
    rd(8'h18, v);
    wr(8'h18, v | 32'h80); e = cyc;
    rd(8'h18, v); chk("R2 rmw keeps fields", v, 32'h92);
    wait_rise(t); chk("R4 first expiry N=3 div=8", t - e, 24);
    t1 = t;

    wr(8'h00, 1); chk("R6 clear drops irq", irq, 0);
    wait_rise(t2); chk("R5 periodic interval", t2 - t1, 24);

    wr(8'h00, 0); chk("R6 write zero ignored", irq, 1);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R1 unmapped reads zero", v, 0);
    rd(8'h18, v); chk("R1 unmapped write no effect", v, 32'h92);

    t3 = t2 + 24;
    wr_at(t3, 8'h00, 1); chk("R6 expire wins over clear", irq, 1);

    wr(8'h00, 1);
    wr(8'h10, 5); e = cyc;
    wait_rise(t); chk("R7 load restarts count", t - e, 40);

    wr(8'h00, 1);
    wr(8'h10, 4); e = cyc;
    wr_at(e + 12, 8'h18, 32'h12);
    repeat (100) @(negedge clk);
    chk("R8 frozen no expiry", irq, 0);
    wr(8'h18, 32'h92); e = cyc;
    wait_rise(t); chk("R8 resume from frozen count", t - e, 24);

    wr(8'h18, 32'h02);
    wr(8'h00, 1);
    wr(8'h10, 2);
    wr(8'h18, 32'h82); e = cyc;
    wait_rise(t); chk("R5 one-shot expiry", t - e, 16);
    wr(8'h00, 1);
    repeat (100) @(negedge clk);
    chk("R5 one-shot stops", irq, 0);

    wr(8'h18, 32'h00);
    wr(8'h10, 3);
    wr(8'h18, 32'h80); e = cyc;
    wait_rise(t); chk("R3 select 0 divides by 2", t - e, 6);

    wr(8'h18, 32'h0E);
    wr(8'h00, 1);
    wr(8'h10, 1);
    wr(8'h18, 32'h8E); e = cyc;
    wait_rise(t); chk("R3 select 14 divides by 32768", t - e, 32768);

    wr(8'h18, 32'h10);
    wr(8'h00, 1);
    wr(8'h10, 0);
    wr(8'h18, 32'h90);
    repeat (50) @(negedge clk);
    chk("R11 zero count idle", irq, 0);

    wr(8'h10, 1);
    repeat (4) @(negedge clk);
    chk("R9 irq set before reset", irq, 1);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    rd(8'h00, v); chk("R9 status cleared by reset", v, 0);
    rd(8'h10, v); chk("R9 load cleared by reset", v, 0);
    rd(8'h18, v); chk("R9 ctrl cleared by reset", v, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule